// File: doc/BRIEF.md
# Programmable Supply Sequencing State Machine

This block is a table-driven state machine that steps a board through its power-up, power-down and fault sequences. It holds up to 63 states in a configuration table. Each state carries three things. The first is the pattern of ten output enables that the state drives. The second is a set of branches to other states. Each branch is conditioned on input events, which are qualified fault flags or logic inputs. The third is a per-state timeout that can serve as a watchdog. A state can also mark some events as warnings, and those events raise an interrupt.

The machine advances only on a slow timebase strobe (`tick`), one strobe per timebase period. Any state change therefore completes within one period. Software writes table entries through a simple write port. Software can also force the machine into any state: the request waits until the next tick and then overrides every other condition. State 0 is the home state after reset, and no output is enabled there.

Top module: `seq_engine`

## Requirements
- R1: While `rst_n` is low at a clock edge, the machine goes to state 0, `irq_o` goes to 0, every table entry is cleared and any pending software request is dropped.
- R2: In state 0, `en_o` is all zeros whatever entry 0 holds. In any other state, `en_o` equals the output field of that state's entry.
- R3: `state_o` and `irq_o` change only at a clock edge where `tick` is high.
- R4: At a tick, the sequence branch is taken to `seq_nxt` when `seq_mask` is nonzero and every event selected by `seq_mask` is high. A zero `seq_mask` disables the branch.
- R5: At a tick, the fault branch is taken to `mon_nxt` when any event selected by `mon_mask` is high. It wins over the sequence branch.
- R6: A nonzero `tmo_len` moves the machine to `tmo_nxt` on the `tmo_len`-th tick after the state was entered, unless some other branch is taken at that tick. A `tmo_len` of 0 disables the timeout. The sequence branch wins over the timeout.
- R7: A pulse on `sw_req` latches `sw_idx`. The first tick after that edge jumps to the latched index, overriding the fault, sequence and timeout branches. A later request before that tick replaces the earlier one.
- R8: At each tick, `irq_o` is loaded with the OR of the events selected by the current state's `warn_mask`, and it holds that value until the next tick.
- R9: A jump target of 63 or above, from any branch or from software, takes the machine to state 0. `state_o` never exceeds 62.
- R10: The timeout count restarts on every transition, including a jump back into the same state.
- R11: `cfg_we` writes `cfg_data` into entry `cfg_idx` at the clock edge, and the entry takes effect from the next cycle. The entry word is 68 bits. From MSB to LSB its fields are: outs[10], seq_mask[8], seq_nxt[6], mon_mask[8], mon_nxt[6], tmo_len[16], tmo_nxt[6], warn_mask[8]. Event bit i of each mask selects `ev[i]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Timebase strobe, one cycle per step |
| ev | input | 8 | Qualified fault flags and logic inputs |
| cfg_we | input | 1 | Table entry write strobe |
| cfg_idx | input | 6 | Entry index for a write |
| cfg_data | input | 68 | Entry word for a write |
| sw_req | input | 1 | Software jump request pulse |
| sw_idx | input | 6 | Software jump target |
| en_o | output | 10 | Output enables of the current state |
| irq_o | output | 1 | Warning interrupt |
| state_o | output | 6 | Current state index |

## Verification
The assertions check four things on every cycle. `state_o` and `irq_o` hold still between ticks. The home state keeps every enable low. `state_o` stays in range. A pending software jump lands on its target at the next tick, mapped to state 0 when out of range.

The bench scenarios cover what depends on programmed table contents. They check the relative priority of the fault, sequence and timeout branches, and the exact tick on which a timeout fires. They check that the timeout count restarts after a jump back into the same state. They also check interrupt values, and that a table write is visible on the enables in the cycle after it.

// File: rtl/seq_pkg.sv
// Shared sizes and the table entry layout of the sequencing engine.
package seq_pkg;
    localparam int SEQ_N_OUT = 10;  // output enables
    localparam int SEQ_N_EV  = 8;   // input events
    localparam int SEQ_SW    = 6;   // state index width
    localparam int SEQ_DEPTH = 63;  // number of states
    localparam int SEQ_TW    = 16;  // timeout count width

    // One state of the table, MSB first.
    typedef struct packed {
        logic [SEQ_N_OUT-1:0] outs;
        logic [SEQ_N_EV-1:0]  seq_mask;
        logic [SEQ_SW-1:0]    seq_nxt;
        logic [SEQ_N_EV-1:0]  mon_mask;
        logic [SEQ_SW-1:0]    mon_nxt;
        logic [SEQ_TW-1:0]    tmo_len;
        logic [SEQ_SW-1:0]    tmo_nxt;
        logic [SEQ_N_EV-1:0]  warn_mask;
    } seq_entry_t;

    localparam int SEQ_ENTRY_W = $bits(seq_entry_t);
endpackage

// File: rtl/seq_table.sv
// State table: one register per entry, one write port, one combinational
// read port. Assumes the read index may reach 2**SEQ_SW-1; indices past
// the depth read as an all-zero entry.
module seq_table import seq_pkg::*; (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [SEQ_SW-1:0] wr_idx,
    input  seq_entry_t wr_data,
    input  logic [SEQ_SW-1:0] rd_idx,
    output seq_entry_t rd_data
);
    seq_entry_t mem [SEQ_DEPTH];

    for (genvar g = 0; g < SEQ_DEPTH; g++) begin : g_ent
        // Store entry g when it is addressed by a write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                mem[g] <= '0;
            else if (wr_en && (wr_idx == SEQ_SW'(g)))
                mem[g] <= wr_data;
        end
    end

    // Read the current state's entry; out-of-range reads as empty.
    always_comb begin
        if (int'(rd_idx) < SEQ_DEPTH) rd_data = mem[rd_idx];
        else                          rd_data = '0;
    end
endmodule

// File: rtl/seq_timer.sv
// Per-state tick counter. Counts ticks since the state was entered and
// flags expiry on the tick that completes tmo_len ticks. Assumes the
// caller asserts restart on every tick that takes a transition.
module seq_timer import seq_pkg::*; (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              restart,
    input  logic [SEQ_TW-1:0] tmo_len,
    output logic              expire
);
    logic [SEQ_TW-1:0] cnt_q;
    logic [SEQ_TW:0]   cnt_inc;

    // Count of ticks after the one now being evaluated.
    assign cnt_inc = {1'b0, cnt_q} + 1'b1;
    assign expire  = tick && (tmo_len != '0) && (cnt_inc == {1'b0, tmo_len});

    // Advance on ticks, clear on entry to a state, saturate at the top.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (restart)
            cnt_q <= '0;
        else if (tick && (cnt_q != '1))
            cnt_q <= cnt_inc[SEQ_TW-1:0];
    end
endmodule

// File: rtl/seq_select.sv
// Next-state choice. Priority, highest first: software jump, fault
// branch, sequence branch, timeout. Targets past the table depth map to
// state 0. Purely combinational; the caller qualifies go with tick.
module seq_select import seq_pkg::*; (
    input  logic [SEQ_N_EV-1:0] ev,
    input  logic [SEQ_N_EV-1:0] seq_mask,
    input  logic [SEQ_SW-1:0]   seq_nxt,
    input  logic [SEQ_N_EV-1:0] mon_mask,
    input  logic [SEQ_SW-1:0]   mon_nxt,
    input  logic [SEQ_SW-1:0]   tmo_nxt,
    input  logic                expire,
    input  logic                pend_v,
    input  logic [SEQ_SW-1:0]   pend_idx,
    output logic                go,
    output logic [SEQ_SW-1:0]   nxt
);
    logic              fault_hit, seq_hit;
    logic [SEQ_SW-1:0] raw;

    assign fault_hit = |(ev & mon_mask);
    assign seq_hit   = (seq_mask != '0) && ((ev & seq_mask) == seq_mask);

    // Pick the winning branch in fixed priority order.
    always_comb begin
        go  = 1'b1;
        raw = '0;
        if (pend_v)         raw = pend_idx;
        else if (fault_hit) raw = mon_nxt;
        else if (seq_hit)   raw = seq_nxt;
        else if (expire)    raw = tmo_nxt;
        else                go  = 1'b0;
    end

    // Fold out-of-range targets onto the home state.
    assign nxt = (int'(raw) < SEQ_DEPTH) ? raw : '0;
endmodule

// File: rtl/seq_engine.sv
// Top of the sequencing engine. Steps the state on tick strobes using the
// table, drives enables from the current state (forced off in state 0),
// holds a software jump until the next tick, and samples warnings into
// irq_o. Assumes ev is already synchronous to clk.
module seq_engine import seq_pkg::*; (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   tick,
    input  logic [SEQ_N_EV-1:0]    ev,
    input  logic                   cfg_we,
    input  logic [SEQ_SW-1:0]      cfg_idx,
    input  logic [SEQ_ENTRY_W-1:0] cfg_data,
    input  logic                   sw_req,
    input  logic [SEQ_SW-1:0]      sw_idx,
    output logic [SEQ_N_OUT-1:0]   en_o,
    output logic                   irq_o,
    output logic [SEQ_SW-1:0]      state_o
);
    seq_entry_t        cur_ent;
    logic [SEQ_SW-1:0] cur_q, nxt, pend_idx;
    logic              pend_v, go, expire, irq_q;

    seq_table u_tab (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_idx  (cfg_idx),
        .wr_data (seq_entry_t'(cfg_data)),
        .rd_idx  (cur_q),
        .rd_data (cur_ent)
    );

    seq_timer u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .restart (tick && go),
        .tmo_len (cur_ent.tmo_len),
        .expire  (expire)
    );

    seq_select u_sel (
        .ev       (ev),
        .seq_mask (cur_ent.seq_mask),
        .seq_nxt  (cur_ent.seq_nxt),
        .mon_mask (cur_ent.mon_mask),
        .mon_nxt  (cur_ent.mon_nxt),
        .tmo_nxt  (cur_ent.tmo_nxt),
        .expire   (expire),
        .pend_v   (pend_v),
        .pend_idx (pend_idx),
        .go       (go),
        .nxt      (nxt)
    );

    // State register: moves only on a tick that selects a branch.
    always_ff @(posedge clk) begin
        if (!rst_n)          cur_q <= '0;
        else if (tick && go) cur_q <= nxt;
    end

    // Software request holding register: newest request wins, a tick consumes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_v   <= 1'b0;
            pend_idx <= '0;
        end else if (sw_req) begin
            pend_v   <= 1'b1;
            pend_idx <= sw_idx;
        end else if (tick) begin
            pend_v   <= 1'b0;
        end
    end

    // Warning interrupt: sampled once per tick from the current state's mask.
    always_ff @(posedge clk) begin
        if (!rst_n)    irq_q <= 1'b0;
        else if (tick) irq_q <= |(ev & cur_ent.warn_mask);
    end

    assign en_o    = (cur_q == '0) ? '0 : cur_ent.outs;
    assign irq_o   = irq_q;
    assign state_o = cur_q;
endmodule

// File: rtl/seq_engine_chk.sv
// Property checker for seq_engine, bound to every instance of it.
module seq_engine_chk import seq_pkg::*; (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 tick,
    input logic                 sw_req,
    input logic [SEQ_N_OUT-1:0] en_o,
    input logic                 irq_o,
    input logic [SEQ_SW-1:0]    state_o,
    input logic                 pend_v,
    input logic [SEQ_SW-1:0]    pend_idx
);
    // R1: reset returns home with the interrupt clear
    p_reset_home_r1: assert property (@(posedge clk)
        !rst_n |=> (state_o == '0) && !irq_o);

    // R2: home state keeps every enable off
    p_home_dark_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == '0) |-> (en_o == '0));

    // R3: no movement between ticks
    p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(state_o) && $stable(irq_o));

    // R7: a request is held until a tick
    p_req_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sw_req |=> pend_v);

    // R7: a held request lands on its (range-folded) target at the tick
    p_sw_lands_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && pend_v && !sw_req) |=>
            (state_o == ((int'($past(pend_idx)) < SEQ_DEPTH) ? $past(pend_idx) : '0)));

    // R9: the state never leaves the table
    p_in_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        int'(state_o) < SEQ_DEPTH);
endmodule

bind seq_engine seq_engine_chk u_chk (.*);

// File: tb/seq_engine_tb.sv
// Scoreboard bench for seq_engine.
module seq_engine_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [7:0]  ev = '0;
    logic        cfg_we = 1'b0;
    logic [5:0]  cfg_idx = '0;
    logic [67:0] cfg_data = '0;
    logic        sw_req = 1'b0;
    logic [5:0]  sw_idx = '0;
    logic [9:0]  en_o;
    logic        irq_o;
    logic [5:0]  state_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [5:0] q_st[$];
    logic [9:0] q_en[$];
    logic       q_irq[$];
    string      q_tag[$];

    seq_engine u_dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [67:0] ent(input logic [9:0] o, input logic [7:0] sm,
        input logic [5:0] sn, input logic [7:0] mm, input logic [5:0] mn,
        input logic [15:0] tl, input logic [5:0] tn, input logic [7:0] wm);
        return {o, sm, sn, mm, mn, tl, tn, wm};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] idx, input logic [67:0] d);
        @(negedge clk); cfg_we = 1'b1; cfg_idx = idx; cfg_data = d;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    // Driver: one tick with given events, expected result pushed to the scoreboard.
    task automatic step(input logic [7:0] e, input logic [5:0] st, input logic [9:0] en,
                        input logic irq, input string tag);
        @(negedge clk);
        ev = e; tick = 1'b1;
        q_st.push_back(st); q_en.push_back(en); q_irq.push_back(irq); q_tag.push_back(tag);
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic req(input logic [5:0] idx);
        @(negedge clk); sw_req = 1'b1; sw_idx = idx;
        @(negedge clk); sw_req = 1'b0;
    endtask

    // Monitor: after each tick edge, pop one expected item and compare.
    initial begin
        forever begin
            @(posedge clk);
            if (tick === 1'b1) begin
                @(negedge clk);
                if (q_st.size() == 0) begin
                    check("scoreboard underflow", 1, 0);
                end else begin
                    automatic string t = q_tag.pop_front();
                    check({t, " state"}, 32'(state_o), 32'(q_st.pop_front()));
                    check({t, " en"},    32'(en_o),    32'(q_en.pop_front()));
                    check({t, " irq"},   32'(irq_o),   32'(q_irq.pop_front()));
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset state", 32'(state_o), 0);
        check("R1 reset en", 32'(en_o), 0);
        check("R1 reset irq", 32'(irq_o), 0);
        rst_n = 1'b1;

        // Table program (R11): 0 home, 1 ramp, 2 hold then power down, 4 idle, 5 faulted
        wr(6'd0, ent(10'h3FF, 8'h01, 6'd1, 8'h00, 6'd0, 16'd0, 6'd0, 8'h00));
        wr(6'd1, ent(10'h001, 8'h06, 6'd2, 8'h80, 6'd5, 16'd3, 6'd4, 8'h40));
        wr(6'd2, ent(10'h003, 8'h00, 6'd0, 8'h00, 6'd0, 16'd2, 6'd0, 8'h00));
        wr(6'd4, ent(10'h200, 8'h00, 6'd0, 8'h00, 6'd0, 16'd0, 6'd0, 8'h00));
        wr(6'd5, ent(10'h3FF, 8'h08, 6'd63, 8'h00, 6'd0, 16'd0, 6'd0, 8'h00));

        step(8'h00, 6'd0, 10'h000, 1'b0, "R2 R4 home stays dark");
        step(8'h01, 6'd1, 10'h001, 1'b0, "R4 sequence advance");
        step(8'h02, 6'd1, 10'h001, 1'b0, "R4 partial mask holds");
        step(8'h00, 6'd1, 10'h001, 1'b0, "R6 timeout count 2");
        step(8'h00, 6'd4, 10'h200, 1'b0, "R6 timeout fires on third tick");
        for (int i = 0; i < 5; i++) step(8'h00, 6'd4, 10'h200, 1'b0, "R6 zero length disabled");

        // R11: write takes effect in the next cycle without a tick
        wr(6'd4, ent(10'h155, 8'h00, 6'd0, 8'h00, 6'd0, 16'd0, 6'd0, 8'h00));
        check("R11 rewritten enables", 32'(en_o), 32'h155);

        // R7 and R3: request pending, no movement until a tick
        req(6'd1);
        repeat (3) @(negedge clk);
        check("R3 R7 held before tick", 32'(state_o), 4);
        step(8'h00, 6'd1, 10'h001, 1'b0, "R7 jump on tick");
        step(8'h00, 6'd1, 10'h001, 1'b0, "R10 count 1");
        req(6'd1);
        step(8'h00, 6'd1, 10'h001, 1'b0, "R10 self jump");
        step(8'h00, 6'd1, 10'h001, 1'b0, "R10 restart count 1");
        step(8'h00, 6'd1, 10'h001, 1'b0, "R10 restart count 2");
        step(8'h00, 6'd4, 10'h155, 1'b0, "R10 timeout after restart");

        req(6'd1);
        step(8'h00, 6'd1, 10'h001, 1'b0, "R7 jump to 1");
        step(8'h86, 6'd5, 10'h3FF, 1'b0, "R5 fault beats sequence");
        step(8'h08, 6'd0, 10'h000, 1'b0, "R9 target 63 folds to home");

        step(8'h01, 6'd1, 10'h001, 1'b0, "R4 advance again");
        step(8'h40, 6'd1, 10'h001, 1'b1, "R8 warning raises irq");
        step(8'h06, 6'd2, 10'h003, 1'b0, "R8 irq clears, R4 advance");
        step(8'h00, 6'd2, 10'h003, 1'b0, "R6 count 1 in state 2");
        step(8'h00, 6'd0, 10'h000, 1'b0, "R6 power down to home");

        step(8'h01, 6'd1, 10'h001, 1'b0, "R4 advance");
        step(8'h01, 6'd1, 10'h001, 1'b0, "R6 count 1");
        step(8'h01, 6'd1, 10'h001, 1'b0, "R6 count 2");
        step(8'h07, 6'd2, 10'h003, 1'b0, "R6 sequence beats timeout");

        req(6'd1);
        step(8'h00, 6'd1, 10'h001, 1'b0, "R7 back to 1");
        req(6'd2);
        step(8'h80, 6'd2, 10'h003, 1'b0, "R7 software beats fault");

        req(6'd4);
        req(6'd62);
        step(8'h00, 6'd62, 10'h000, 1'b0, "R7 newer request replaces");
        req(6'd63);
        step(8'h00, 6'd0, 10'h000, 1'b0, "R9 software target 63 folds");

        repeat (2) @(negedge clk);
        check("scoreboard drained", 32'(q_st.size()), 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule